// File: doc/BRIEF.md
# CAN identifier acceptance filter

This block decides whether a CAN frame, already sitting complete in a background receive buffer, is reported to the CPU. Eight byte-wide registers hold the filter: four acceptance code bytes and four mask bytes, one pair for each of the identifier bytes 0 to 3. When the frame decoder strobes `frame_done`, each identifier bit is compared with its code bit. Where a mask bit is set, that position is ignored. A standard frame is judged on identifier bytes 0 and 1 only. An extended frame is judged on all four bytes.

If the frame passes, the filter pulses `frame_accept` and sets the sticky `rx_ready` flag. The flag stays set until the CPU clears it. A frame that fails raises nothing, and the next frame simply overwrites it in the buffer. The filter registers can be changed only while the `cfg_unlock` input is high. That input mirrors the controller's soft-reset control bit. A hardware reset leaves the filter contents untouched.

Top module: `can_id_filter`

## Requirements
- R1: The register map is as follows. Addresses 0 to 3 hold the acceptance code for identifier bytes 0 to 3. Addresses 4 to 7 hold the mask for identifier bytes 0 to 3. `reg_rdata` shows the register at `reg_addr` one clock after that address is applied, and reads are always allowed.
- R2: A write (`reg_we` high) changes a register only when `cfg_unlock` is high in the same cycle. At any other time the write is ignored and every register keeps its value.
- R3: A hardware reset (`rst` high) clears `reg_rdata`, `frame_accept` and `rx_ready`. It leaves all eight filter registers unchanged.
- R4: Identifier byte k sits on `rx_id[8k+7:8k]`. A bit passes when its mask bit is 1, or when it equals its code bit. A frame passes only if every bit in every used byte passes.
- R5: A standard frame (`frame_ext` = 0) uses bytes 0 and 1 only. The contents of bytes 2 and 3 have no effect on the decision.
- R6: An extended frame (`frame_ext` = 1) uses all four bytes. A mismatch in byte 2 or byte 3 rejects it.
- R7: `frame_accept` is high for exactly the one clock after a `frame_done` strobe whose frame passes. It is low at every other time.
- R8: A passing frame sets `rx_ready`, which is seen one clock after the strobe. A failing frame never sets it.
- R9: `rx_ready` stays high until `ready_clr` is asserted, and it is low one clock after `ready_clr`. A clear wins over a frame that completes in the same cycle. A frame that completes while the flag is set leaves the flag as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_unlock | input | 1 | Soft-reset state; enables filter register writes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0-3 code, 4-7 mask) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| frame_done | input | 1 | One-cycle strobe: a frame is complete in the buffer |
| frame_ext | input | 1 | Frame format sampled with the strobe (1 = extended) |
| rx_id | input | 32 | Identifier bytes 0-3 of the buffered frame |
| ready_clr | input | 1 | CPU clears the receive-ready flag |
| frame_accept | output | 1 | One-cycle accept pulse |
| rx_ready | output | 1 | Sticky receive-ready flag |

## Verification
Every result of this block is due one clock after its cause. Read data appears one clock after the address is applied. The accept pulse and the flag set follow a `frame_done` strobe by one clock, and the flag drop follows `ready_clr` by one clock. The bench drives each stimulus on a falling edge and samples exactly one falling edge later, so exactly one rising edge lies between the two. It then samples again a cycle later to confirm that the accept pulse has ended while the flag holds.

// File: rtl/acf_pkg.sv
package acf_pkg;
  localparam int unsigned ACF_BYTE_W    = 8;
  localparam int unsigned ACF_ID_BYTES  = 4;
  localparam int unsigned ACF_STD_BYTES = 2;

  typedef enum logic {
    FMT_STD = 1'b0,
    FMT_EXT = 1'b1
  } acf_fmt_e;
endpackage

// File: rtl/acf_regfile.sv
module acf_regfile #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned ID_BYTES = 4,
  parameter int unsigned AW       = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic                             unlock,
  input  logic [AW-1:0]                    addr,
  input  logic [BYTE_W-1:0]                wdata,
  output logic [BYTE_W-1:0]                rdata,
  output logic [ID_BYTES-1:0][BYTE_W-1:0]  code_o,
  output logic [ID_BYTES-1:0][BYTE_W-1:0]  mask_o
);
  localparam int unsigned REGS = 2 * ID_BYTES;

  // storage has no reset: contents survive a hardware reset
  logic [BYTE_W-1:0] mem [REGS];

  always_ff @(posedge clk) begin
    if (wr_en && unlock) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[addr];
  end

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_tap
    assign code_o[g] = mem[g];
    assign mask_o[g] = mem[ID_BYTES + g];
  end
endmodule

// File: rtl/acf_match.sv
module acf_match #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned ID_BYTES  = 4,
  parameter int unsigned STD_BYTES = 2
) (
  input  logic [ID_BYTES-1:0][BYTE_W-1:0] code_i,
  input  logic [ID_BYTES-1:0][BYTE_W-1:0] mask_i,
  input  logic [ID_BYTES-1:0][BYTE_W-1:0] id_i,
  input  acf_pkg::acf_fmt_e               fmt_i,
  output logic                            hit_o
);
  logic [ID_BYTES-1:0] byte_ok;
  logic [ID_BYTES-1:0] byte_used;

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_byte
    assign byte_ok[g] = &(~(id_i[g] ^ code_i[g]) | mask_i[g]);
    if (g < STD_BYTES) begin : g_std
      assign byte_used[g] = 1'b1;
    end else begin : g_ext
      assign byte_used[g] = (fmt_i == acf_pkg::FMT_EXT);
    end
  end

  assign hit_o = &(byte_ok | ~byte_used);
endmodule

// File: rtl/acf_flag.sv
module acf_flag (
  input  logic clk,
  input  logic rst,
  input  logic frame_done,
  input  logic hit,
  input  logic ready_clr,
  output logic accept_o,
  output logic ready_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      accept_o <= 1'b0;
      ready_o  <= 1'b0;
    end else begin
      accept_o <= frame_done && hit;
      if (ready_clr)              ready_o <= 1'b0;
      else if (frame_done && hit) ready_o <= 1'b1;
    end
  end
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter #(
  parameter int unsigned BYTE_W    = acf_pkg::ACF_BYTE_W,
  parameter int unsigned ID_BYTES  = acf_pkg::ACF_ID_BYTES,
  parameter int unsigned STD_BYTES = acf_pkg::ACF_STD_BYTES,
  localparam int unsigned REGS     = 2 * ID_BYTES,
  localparam int unsigned AW       = $clog2(REGS),
  localparam int unsigned ID_W     = BYTE_W * ID_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_unlock,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              frame_done,
  input  logic              frame_ext,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              ready_clr,
  output logic              frame_accept,
  output logic              rx_ready
);
  logic [ID_BYTES-1:0][BYTE_W-1:0] code_q;
  logic [ID_BYTES-1:0][BYTE_W-1:0] mask_q;
  logic [ID_BYTES-1:0][BYTE_W-1:0] id_bytes;
  acf_pkg::acf_fmt_e               fmt;
  logic                            hit;

  assign id_bytes = rx_id;
  assign fmt      = frame_ext ? acf_pkg::FMT_EXT : acf_pkg::FMT_STD;

  acf_regfile #(.BYTE_W(BYTE_W), .ID_BYTES(ID_BYTES), .AW(AW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_we), .unlock(cfg_unlock),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .code_o(code_q), .mask_o(mask_q)
  );

  acf_match #(.BYTE_W(BYTE_W), .ID_BYTES(ID_BYTES), .STD_BYTES(STD_BYTES)) match_i (
    .code_i(code_q), .mask_i(mask_q), .id_i(id_bytes), .fmt_i(fmt), .hit_o(hit)
  );

  acf_flag flag_i (
    .clk(clk), .rst(rst), .frame_done(frame_done), .hit(hit),
    .ready_clr(ready_clr), .accept_o(frame_accept), .ready_o(rx_ready)
  );
endmodule

// File: rtl/acf_chk.sv
module acf_chk #(
  parameter int unsigned ID_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_unlock,
  input logic            reg_we,
  input logic            frame_done,
  input logic            ready_clr,
  input logic            frame_accept,
  input logic            rx_ready,
  input logic [ID_W-1:0] code_q,
  input logic [ID_W-1:0] mask_q
);
  // R2
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && cfg_unlock) |=> ($stable(code_q) && $stable(mask_q)));

  // R7
  accept_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    frame_accept |-> $past(frame_done));

  // R8
  ready_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ready) |-> frame_accept);

  // R9
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !ready_clr) |=> rx_ready);

  // R9
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ready_clr |=> !rx_ready);
endmodule

bind can_id_filter acf_chk #(.ID_W(ID_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_unlock(cfg_unlock), .reg_we(reg_we),
  .frame_done(frame_done), .ready_clr(ready_clr),
  .frame_accept(frame_accept), .rx_ready(rx_ready),
  .code_q(code_q), .mask_q(mask_q)
);

// File: tb/can_id_filter_tb.sv
module can_id_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_unlock;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        frame_done;
  logic        frame_ext;
  logic [31:0] rx_id;
  logic        ready_clr;
  logic        frame_accept;
  logic        rx_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  can_id_filter dut_i (
    .clk(clk), .rst(rst), .cfg_unlock(cfg_unlock), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_done(frame_done), .frame_ext(frame_ext), .rx_id(rx_id),
    .ready_clr(ready_clr), .frame_accept(frame_accept), .rx_ready(rx_ready)
  );

  // filter: code bytes A5 3C F0 0F, masks 00 0F 00 F0
  localparam logic [7:0] CODE [4] = '{8'hA5, 8'h3C, 8'hF0, 8'h0F};
  localparam logic [7:0] MASK [4] = '{8'h00, 8'h0F, 8'h00, 8'hF0};

  // {kind(0:R4,1:R5,2:R6), ext, id, expect}
  localparam int NV = 9;
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 1'b0, 32'h00003CA5, 1'b1},
    {2'd0, 1'b0, 32'h000037A5, 1'b1},
    {2'd0, 1'b0, 32'h00004CA5, 1'b0},
    {2'd0, 1'b0, 32'h00003CA4, 1'b0},
    {2'd2, 1'b1, 32'h5FF03CA5, 1'b1},
    {2'd2, 1'b1, 32'h0EF03CA5, 1'b0},
    {2'd2, 1'b1, 32'h0FF13CA5, 1'b0},
    {2'd1, 1'b0, 32'h0FF13CA5, 1'b1},
    {2'd1, 1'b0, 32'hFFFF3CA5, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    @(negedge clk);
    chk(req, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic frame(input logic ext, input logic [31:0] id, input logic clr);
    frame_done = 1'b1; frame_ext = ext; rx_id = id; ready_clr = clr;
    @(negedge clk);
    frame_done = 1'b0; ready_clr = 1'b0;
  endtask

  task automatic clear_flag();
    ready_clr = 1'b1;
    @(negedge clk);
    ready_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_unlock = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    frame_done = 1'b0; frame_ext = 1'b0; rx_id = '0; ready_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 reset rx_ready", {31'd0, rx_ready}, 32'd0);
    chk("R3 reset frame_accept", {31'd0, frame_accept}, 32'd0);
    chk("R3 reset reg_rdata", {24'd0, reg_rdata}, 32'd0);
    rst = 1'b0;

    cfg_unlock = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wr(3'(i), CODE[i]);
      wr(3'(4 + i), MASK[i]);
    end
    cfg_unlock = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), CODE[i], "R1 code readback");
      rd(3'(4 + i), MASK[i], "R1 mask readback");
    end

    // R2: locked writes ignored
    wr(3'd0, 8'hFF);
    wr(3'd5, 8'hAA);
    rd(3'd0, CODE[0], "R2 locked code write");
    rd(3'd5, MASK[1], "R2 locked mask write");

    // R3: hardware reset keeps filter contents
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    rd(3'd0, CODE[0], "R3 code kept over reset");
    rd(3'd7, MASK[3], "R3 mask kept over reset");

    for (int v = 0; v < NV; v++) begin
      logic [1:0] kind;
      logic       expv;
      string      tag;
      kind = VEC[v][35:34];
      expv = VEC[v][0];
      case (kind)
        2'd0:    tag = "R4 bit compare";
        2'd1:    tag = "R5 standard bytes 2-3 ignored";
        default: tag = "R6 extended all bytes";
      endcase
      frame(VEC[v][33], VEC[v][32:1], 1'b0);
      chk(tag, {31'd0, frame_accept}, {31'd0, expv});
      chk("R8 flag follows decision", {31'd0, rx_ready}, {31'd0, expv});
      @(negedge clk);
      chk("R7 accept is one cycle", {31'd0, frame_accept}, 32'd0);
      if (expv) begin
        clear_flag();
        chk("R9 clear drops flag", {31'd0, rx_ready}, 32'd0);
      end
    end

    // R9: sticky flag behaviour
    frame(1'b0, 32'h00003CA5, 1'b0);
    chk("R8 accepted sets flag", {31'd0, rx_ready}, 32'd1);
    frame(1'b0, 32'h00003CA4, 1'b0);
    chk("R7 rejected no pulse", {31'd0, frame_accept}, 32'd0);
    chk("R9 rejected frame keeps flag", {31'd0, rx_ready}, 32'd1);
    frame(1'b1, 32'h5FF03CA5, 1'b0);
    chk("R7 accept while flag set", {31'd0, frame_accept}, 32'd1);
    chk("R9 flag held", {31'd0, rx_ready}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R9 flag stays without clear", {31'd0, rx_ready}, 32'd1);
    frame(1'b0, 32'h00003CA5, 1'b1);
    chk("R9 clear wins over frame", {31'd0, rx_ready}, 32'd0);
    chk("R7 accept with clear", {31'd0, frame_accept}, 32'd1);
    frame(1'b0, 32'h00003CA5, 1'b0);
    chk("R8 set after clear", {31'd0, rx_ready}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R3 reset clears flag", {31'd0, rx_ready}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule